// File: doc/BRIEF.md
# Receive Destination Address Filter

This block decides, one frame at a time, whether an incoming Ethernet frame is kept, judged only on its 48-bit destination address. The receive path presents the address with a one-cycle strobe. One clock later the block returns an accept flag and a type code that marks the frame as plain, multicast or broadcast. Three mode inputs open the filter wider: keep every unicast frame, keep every group-addressed frame, and keep the all-ones address. When none of these applies, the address is compared against a table of station addresses, and only entries switched on by an enable mask take part.

The address table is filled from memory by a small sequencer. A load command gives it a byte pointer, a descriptor count and a width flag. It then walks a list of four-word descriptors, taking three words of each as the six address bytes. After the list, it reads one more word as the enable mask, clears its busy flag and pulses a done event.

While the block is held in its soft-reset mode, a read port gives software a view of any table entry, one 16-bit word at a time. Outside that mode the port reads as zero.

Top module: `rx_addr_filter`

## Requirements
- R1: The address byte that travels first sits in `dst_addr[7:0]`, and its bit 0 is the group bit. With `mode_promisc` set, an address whose group bit is clear is accepted with kind 0 (plain).
- R2: If R1 did not accept, then with `mode_all_mcast` set an address whose group bit is set is accepted with kind 1 (multicast).
- R3: If neither R1 nor R2 accepted, then with `mode_bcast` set an all-ones address is accepted with kind 2 (broadcast). An all-ones address with `mode_all_mcast` also set is therefore tagged multicast.
- R4: Otherwise the address is accepted with kind 0 when it equals a table entry whose enable-mask bit is set. Entries with a clear mask bit never match. Any other address is rejected, with accept 0 and kind 0.
- R5: `match_valid` is high for exactly the one cycle after a cycle with `dst_valid` high, and carries that strobe's result. In every other cycle `match_accept` and `match_kind` are 0.
- R6: A load fetches descriptors while the low 5 bits of the remaining count are nonzero. Bits above those are ignored. Descriptor word k lies at pointer + 2k bytes, or pointer + 4k when `load_wide` is set. Only words 1, 2 and 3 are read. They give address bytes {1,0}, {3,2} and {5,4}, with the low byte of each word being the lower-numbered byte.
- R7: Each descriptor decrements the count and moves the pointer on by 8 bytes, or by 16 bytes in wide mode. Descriptor n goes to entry n mod 16. After the last descriptor, word 0 at the final pointer is read and becomes the enable mask, with bit i enabling entry i. A count whose low 5 bits are zero reads only this mask word.
- R8: `load_busy` rises the cycle after an accepted `load_start`. When the load completes, it falls in the same cycle that `load_done` pulses high for one cycle. Reset leaves the table and the mask at zero and the sequencer idle.
- R9: While `reset_mode` is high, `cam_rd_data` shows the entry selected by `cam_sel`: word 0 is bytes {1,0}, word 1 is bytes {3,2}, word 2 is bytes {5,4}, and word 3 reads 0. While `reset_mode` is low, it reads 0.
- R10: A strobe in the same cycle as a table entry update is compared against the entry's old contents. Until the mask word arrives, the old enable mask stays in force. A `load_start` while `load_busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| mode_promisc | input | 1 | Keep every unicast address |
| mode_all_mcast | input | 1 | Keep every group address |
| mode_bcast | input | 1 | Keep the all-ones address |
| reset_mode | input | 1 | Soft-reset mode; opens the table read port |
| dst_valid | input | 1 | Destination address strobe |
| dst_addr | input | 48 | Destination address; first byte in [7:0] |
| match_valid | output | 1 | Result valid, one cycle after the strobe |
| match_accept | output | 1 | Frame accepted |
| match_kind | output | 2 | 0 plain, 1 multicast, 2 broadcast |
| load_start | input | 1 | Start a table load |
| load_ptr | input | PTR_W | Byte address of the first descriptor |
| load_count | input | CNT_W | Descriptor count; low 5 bits are used |
| load_wide | input | 1 | 32-bit memory layout |
| load_busy | output | 1 | Load in progress |
| load_done | output | 1 | One-cycle pulse when a load ends |
| mem_rd_en | output | 1 | Memory word read request |
| mem_rd_addr | output | PTR_W | Byte address of the requested word |
| mem_rd_valid | input | 1 | Read data valid |
| mem_rd_data | input | 16 | Read data |
| cam_sel | input | IDX_W | Table entry selected for the read port |
| cam_word | input | 2 | Word of the selected entry |
| cam_rd_data | output | 16 | Table read port data |

## Verification
The compare of a strobed address and the write of a table entry by the sequencer can land in the same clock edge. The bench watches the memory read requests during a load. When it sees the request for word 3 of a chosen descriptor, it places a strobe in the cycle when that word's data returns, which is the edge at which the entry is rewritten. The strobe carries the entry's old address, and the bench expects it to be accepted as plain. After the load, the same address must be rejected, and the read port and the new mask must show the new contents.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
   localparam int MAC_W  = 48;
   localparam int WORD_W = 16;

   typedef enum logic [1:0] {
      KIND_PLAIN = 2'd0,
      KIND_MCAST = 2'd1,
      KIND_BCAST = 2'd2
   } frame_kind_e;

   typedef enum logic [1:0] {
      LD_IDLE  = 2'd0,
      LD_CHECK = 2'd1,
      LD_ISSUE = 2'd2,
      LD_WAIT  = 2'd3
   } ld_state_e;
endpackage

// File: rtl/rxf_cam_store.sv
module rxf_cam_store
   import rxf_pkg::*;
#(
   parameter int ENTRIES = 16,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [IDX_W-1:0]   wr_idx,
   input  logic [MAC_W-1:0]   wr_addr,
   input  logic               mask_wr_en,
   input  logic [ENTRIES-1:0] mask_wr_data,
   input  logic [IDX_W-1:0]   rd_idx,
   input  logic [1:0]         rd_word,
   output logic [WORD_W-1:0]  rd_data,
   input  logic [MAC_W-1:0]   probe_addr,
   output logic [ENTRIES-1:0] hit_vec
);
   logic [MAC_W-1:0]   entry_q [ENTRIES];
   logic [ENTRIES-1:0] mask_q;
   logic [MAC_W-1:0]   sel_entry;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < ENTRIES; i++) entry_q[i] <= '0;
         mask_q <= '0;
      end else begin
         if (wr_en)      entry_q[wr_idx] <= wr_addr;
         if (mask_wr_en) mask_q <= mask_wr_data;
      end
   end

   // one comparator per entry, all in parallel
   for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
      assign hit_vec[g] = mask_q[g] && (entry_q[g] == probe_addr);
   end

   assign sel_entry = entry_q[rd_idx];

   always_comb begin
      case (rd_word)
         2'd0:    rd_data = sel_entry[15:0];
         2'd1:    rd_data = sel_entry[31:16];
         2'd2:    rd_data = sel_entry[47:32];
         default: rd_data = '0;
      endcase
   end
endmodule

// File: rtl/rxf_matcher.sv
module rxf_matcher
   import rxf_pkg::*;
#(
   parameter int ENTRIES = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               strobe,
   input  logic [MAC_W-1:0]   addr,
   input  logic               promisc,
   input  logic               all_mcast,
   input  logic               bcast,
   input  logic [ENTRIES-1:0] hit_vec,
   output logic               res_valid,
   output logic               res_accept,
   output frame_kind_e        res_kind
);
   logic        group_bit;
   logic        all_ones;
   logic        dec_accept;
   frame_kind_e dec_kind;

   assign group_bit = addr[0];
   assign all_ones  = &addr;

   // fixed priority: promiscuous unicast, group, broadcast, table
   always_comb begin
      dec_accept = 1'b0;
      dec_kind   = KIND_PLAIN;
      if (promisc && !group_bit) begin
         dec_accept = 1'b1;
      end else if (all_mcast && group_bit) begin
         dec_accept = 1'b1;
         dec_kind   = KIND_MCAST;
      end else if (bcast && all_ones) begin
         dec_accept = 1'b1;
         dec_kind   = KIND_BCAST;
      end else if (|hit_vec) begin
         dec_accept = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid  <= 1'b0;
         res_accept <= 1'b0;
         res_kind   <= KIND_PLAIN;
      end else begin
         res_valid  <= strobe;
         res_accept <= strobe && dec_accept;
         res_kind   <= strobe ? dec_kind : KIND_PLAIN;
      end
   end
endmodule

// File: rtl/rxf_loader.sv
module rxf_loader
   import rxf_pkg::*;
#(
   parameter int ENTRIES = 16,
   parameter int PTR_W   = 16,
   parameter int CNT_W   = 16,
   parameter int TEST_W  = 5,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [PTR_W-1:0]   ptr_init,
   input  logic [CNT_W-1:0]   cnt_init,
   input  logic               wide,
   output logic               busy,
   output logic               done,
   output logic               mem_rd_en,
   output logic [PTR_W-1:0]   mem_rd_addr,
   input  logic               mem_rd_valid,
   input  logic [WORD_W-1:0]  mem_rd_data,
   output logic               wr_en,
   output logic [IDX_W-1:0]   wr_idx,
   output logic [MAC_W-1:0]   wr_addr,
   output logic               mask_wr_en,
   output logic [ENTRIES-1:0] mask_wr_data
);
   localparam logic [PTR_W-1:0] STEP_NARROW = PTR_W'(8);
   localparam logic [PTR_W-1:0] STEP_WIDE   = PTR_W'(16);

   ld_state_e         state_q;
   logic [PTR_W-1:0]  ptr_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [IDX_W-1:0]  idx_q;
   logic [1:0]        word_q;
   logic              mask_phase_q;
   logic              wide_q;
   logic [WORD_W-1:0] w1_q, w2_q;
   logic [PTR_W-1:0]  word_off;
   logic              rd_back;

   assign word_off    = wide_q ? (PTR_W'(word_q) << 2) : (PTR_W'(word_q) << 1);
   assign mem_rd_addr = ptr_q + word_off;
   assign mem_rd_en   = (state_q == LD_ISSUE);
   assign rd_back     = (state_q == LD_WAIT) && mem_rd_valid;

   assign wr_en        = rd_back && !mask_phase_q && (word_q == 2'd3);
   assign wr_idx       = idx_q;
   assign wr_addr      = {mem_rd_data, w2_q, w1_q};
   assign mask_wr_en   = rd_back && mask_phase_q;
   assign mask_wr_data = mem_rd_data[ENTRIES-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q      <= LD_IDLE;
         ptr_q        <= '0;
         cnt_q        <= '0;
         idx_q        <= '0;
         word_q       <= '0;
         mask_phase_q <= 1'b0;
         wide_q       <= 1'b0;
         w1_q         <= '0;
         w2_q         <= '0;
         busy         <= 1'b0;
         done         <= 1'b0;
      end else begin
         done <= 1'b0;
         case (state_q)
            LD_IDLE: begin
               if (start) begin
                  ptr_q   <= ptr_init;
                  cnt_q   <= cnt_init;
                  wide_q  <= wide;
                  idx_q   <= '0;
                  busy    <= 1'b1;
                  state_q <= LD_CHECK;
               end
            end
            LD_CHECK: begin
               if (|cnt_q[TEST_W-1:0]) begin
                  word_q       <= 2'd1;
                  mask_phase_q <= 1'b0;
               end else begin
                  word_q       <= 2'd0;
                  mask_phase_q <= 1'b1;
               end
               state_q <= LD_ISSUE;
            end
            LD_ISSUE: state_q <= LD_WAIT;
            LD_WAIT: begin
               if (mem_rd_valid) begin
                  if (mask_phase_q) begin
                     busy    <= 1'b0;
                     done    <= 1'b1;
                     state_q <= LD_IDLE;
                  end else begin
                     case (word_q)
                        2'd1: begin
                           w1_q    <= mem_rd_data;
                           word_q  <= 2'd2;
                           state_q <= LD_ISSUE;
                        end
                        2'd2: begin
                           w2_q    <= mem_rd_data;
                           word_q  <= 2'd3;
                           state_q <= LD_ISSUE;
                        end
                        default: begin
                           cnt_q   <= cnt_q - 1'b1;
                           ptr_q   <= ptr_q + (wide_q ? STEP_WIDE : STEP_NARROW);
                           idx_q   <= idx_q + 1'b1;
                           state_q <= LD_CHECK;
                        end
                     endcase
                  end
               end
            end
            default: state_q <= LD_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
   import rxf_pkg::*;
#(
   parameter int ENTRIES = 16,
   parameter int PTR_W   = 16,
   parameter int CNT_W   = 16,
   parameter int TEST_W  = 5,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               mode_promisc,
   input  logic               mode_all_mcast,
   input  logic               mode_bcast,
   input  logic               reset_mode,
   input  logic               dst_valid,
   input  logic [47:0]        dst_addr,
   output logic               match_valid,
   output logic               match_accept,
   output logic [1:0]         match_kind,
   input  logic               load_start,
   input  logic [PTR_W-1:0]   load_ptr,
   input  logic [CNT_W-1:0]   load_count,
   input  logic               load_wide,
   output logic               load_busy,
   output logic               load_done,
   output logic               mem_rd_en,
   output logic [PTR_W-1:0]   mem_rd_addr,
   input  logic               mem_rd_valid,
   input  logic [15:0]        mem_rd_data,
   input  logic [IDX_W-1:0]   cam_sel,
   input  logic [1:0]         cam_word,
   output logic [15:0]        cam_rd_data
);
   if (ENTRIES < 2 || ENTRIES > WORD_W || (ENTRIES & (ENTRIES - 1)) != 0) begin : g_bad_entries
      $error("ENTRIES must be a power of two between 2 and the word width");
   end
   if (TEST_W < 1 || TEST_W > CNT_W) begin : g_bad_test
      $error("TEST_W must lie within CNT_W");
   end
   if (PTR_W < 8) begin : g_bad_ptr
      $error("PTR_W too small for descriptor stepping");
   end

   logic               wr_en, mask_wr_en;
   logic [IDX_W-1:0]   wr_idx;
   logic [MAC_W-1:0]   wr_addr;
   logic [ENTRIES-1:0] mask_wr_data;
   logic [ENTRIES-1:0] hit_vec;
   logic [WORD_W-1:0]  raw_rd;
   frame_kind_e        kind_q;

   rxf_loader #(
      .ENTRIES(ENTRIES), .PTR_W(PTR_W), .CNT_W(CNT_W), .TEST_W(TEST_W)
   ) u_loader (
      .clk(clk), .rst_n(rst_n),
      .start(load_start && !load_busy),
      .ptr_init(load_ptr), .cnt_init(load_count), .wide(load_wide),
      .busy(load_busy), .done(load_done),
      .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
      .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_addr(wr_addr),
      .mask_wr_en(mask_wr_en), .mask_wr_data(mask_wr_data)
   );

   rxf_cam_store #(.ENTRIES(ENTRIES)) u_store (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_addr(wr_addr),
      .mask_wr_en(mask_wr_en), .mask_wr_data(mask_wr_data),
      .rd_idx(cam_sel), .rd_word(cam_word), .rd_data(raw_rd),
      .probe_addr(dst_addr), .hit_vec(hit_vec)
   );

   rxf_matcher #(.ENTRIES(ENTRIES)) u_match (
      .clk(clk), .rst_n(rst_n),
      .strobe(dst_valid), .addr(dst_addr),
      .promisc(mode_promisc), .all_mcast(mode_all_mcast), .bcast(mode_bcast),
      .hit_vec(hit_vec),
      .res_valid(match_valid), .res_accept(match_accept), .res_kind(kind_q)
   );

   assign match_kind  = kind_q;
   assign cam_rd_data = reset_mode ? raw_rd : '0;
endmodule

// File: rtl/rxf_chk.sv
module rxf_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        mode_promisc,
   input logic        mode_all_mcast,
   input logic        mode_bcast,
   input logic        reset_mode,
   input logic        dst_valid,
   input logic [47:0] dst_addr,
   input logic        match_valid,
   input logic        match_accept,
   input logic [1:0]  match_kind,
   input logic        load_busy,
   input logic        load_done,
   input logic        mem_rd_en,
   input logic [15:0] cam_rd_data
);
   a_r5_follows_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      dst_valid |=> match_valid);

   a_r5_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
      match_valid |-> $past(dst_valid));

   a_r5_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !match_valid |-> (!match_accept && match_kind == 2'd0));

   a_r1_promisc_plain: assert property (@(posedge clk) disable iff (!rst_n)
      (match_valid && $past(mode_promisc) && !$past(dst_addr[0]))
      |-> (match_accept && match_kind == 2'd0));

   a_r2_mcast_cause: assert property (@(posedge clk) disable iff (!rst_n)
      (match_kind == 2'd1) |-> ($past(dst_addr[0]) && $past(mode_all_mcast)));

   a_r3_bcast_cause: assert property (@(posedge clk) disable iff (!rst_n)
      (match_kind == 2'd2) |-> (($past(dst_addr) == {48{1'b1}}) && $past(mode_bcast)
                                && !$past(mode_all_mcast)));

   a_r6_reads_only_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_en |-> load_busy);

   a_r8_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
      load_done |-> (!load_busy && $past(load_busy)));

   a_r9_port_closed: assert property (@(posedge clk) disable iff (!rst_n)
      !reset_mode |-> (cam_rd_data == 16'd0));
endmodule

bind rx_addr_filter rxf_chk u_chk (
   .clk(clk), .rst_n(rst_n),
   .mode_promisc(mode_promisc), .mode_all_mcast(mode_all_mcast), .mode_bcast(mode_bcast),
   .reset_mode(reset_mode), .dst_valid(dst_valid), .dst_addr(dst_addr),
   .match_valid(match_valid), .match_accept(match_accept), .match_kind(match_kind),
   .load_busy(load_busy), .load_done(load_done), .mem_rd_en(mem_rd_en),
   .cam_rd_data(cam_rd_data)
);

// File: tb/rx_addr_filter_test.sv
module rx_addr_filter_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mode_promisc = 0, mode_all_mcast = 0, mode_bcast = 0, reset_mode = 0;
   logic        dst_valid = 0;
   logic [47:0] dst_addr = '0;
   logic        match_valid, match_accept;
   logic [1:0]  match_kind;
   logic        load_start = 0, load_wide = 0;
   logic [15:0] load_ptr = '0, load_count = '0;
   logic        load_busy, load_done, mem_rd_en;
   logic [15:0] mem_rd_addr;
   logic        mem_rd_valid = 0;
   logic [15:0] mem_rd_data = '0;
   logic [3:0]  cam_sel = '0;
   logic [1:0]  cam_word = '0;
   logic [15:0] cam_rd_data;

   int checks = 0, errors = 0;
   logic [15:0] mem [0:1023];
   logic [47:0] ref_cam [16];
   logic [15:0] ref_mask = '0;
   logic [15:0] trace [64];
   int          trace_n = 0;
   logic [15:0] exp_trace [64];
   int          exp_n = 0;

   always #4 clk = ~clk;

   rx_addr_filter uut (
      .clk(clk), .rst_n(rst_n),
      .mode_promisc(mode_promisc), .mode_all_mcast(mode_all_mcast), .mode_bcast(mode_bcast),
      .reset_mode(reset_mode), .dst_valid(dst_valid), .dst_addr(dst_addr),
      .match_valid(match_valid), .match_accept(match_accept), .match_kind(match_kind),
      .load_start(load_start), .load_ptr(load_ptr), .load_count(load_count),
      .load_wide(load_wide), .load_busy(load_busy), .load_done(load_done),
      .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
      .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
      .cam_sel(cam_sel), .cam_word(cam_word), .cam_rd_data(cam_rd_data)
   );

   // memory: one-cycle read latency
   always @(posedge clk) begin
      mem_rd_valid <= mem_rd_en;
      mem_rd_data  <= mem[mem_rd_addr[10:1]];
   end

   always @(negedge clk) begin
      if (mem_rd_en && trace_n < 64) begin
         trace[trace_n] = mem_rd_addr;
         trace_n = trace_n + 1;
      end
   end

   function automatic logic [15:0] rd16(input logic [15:0] a);
      return mem[a[10:1]];
   endfunction

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // expected table state and read trace from the load rules (R6, R7)
   task automatic ref_load(input logic [15:0] ptr, input logic [15:0] cnt, input bit wide);
      logic [15:0] ws = wide ? 16'd4 : 16'd2;
      logic [15:0] st = wide ? 16'd16 : 16'd8;
      int n = int'(cnt[4:0]);
      logic [15:0] base;
      exp_n = 0;
      for (int d = 0; d < n; d++) begin
         base = ptr + 16'(d) * st;
         ref_cam[d % 16] = {rd16(base + 16'd3 * ws), rd16(base + 16'd2 * ws), rd16(base + ws)};
         exp_trace[exp_n] = base + ws;         exp_n++;
         exp_trace[exp_n] = base + 16'd2 * ws; exp_n++;
         exp_trace[exp_n] = base + 16'd3 * ws; exp_n++;
      end
      base = ptr + 16'(n) * st;
      ref_mask = rd16(base);
      exp_trace[exp_n] = base; exp_n++;
   endtask

   function automatic logic [2:0] ref_decide(input logic [47:0] a, input bit p, input bit m, input bit b);
      if (p && !a[0]) return 3'b100;
      if (m && a[0]) return 3'b101;
      if (b && a == {48{1'b1}}) return 3'b110;
      for (int i = 0; i < 16; i++)
         if (ref_mask[i] && ref_cam[i] == a) return 3'b100;
      return 3'b000;
   endfunction

   task automatic strobe_check(input string req, input logic [47:0] a, input bit p, input bit m, input bit b);
      @(negedge clk);
      mode_promisc = p; mode_all_mcast = m; mode_bcast = b;
      dst_addr = a; dst_valid = 1'b1;
      @(negedge clk);
      dst_valid = 1'b0;
      chk(req, {61'd0, match_valid, match_accept, match_kind[1]} , {61'd0, 1'b1, ref_decide(a, p, m, b)[2:1]});
      chk(req, 64'(match_kind), 64'(ref_decide(a, p, m, b)[1:0]));
   endtask

   task automatic start_load(input logic [15:0] ptr, input logic [15:0] cnt, input bit wide);
      @(negedge clk);
      ref_load(ptr, cnt, wide);
      trace_n = 0;
      load_ptr = ptr; load_count = cnt; load_wide = wide; load_start = 1'b1;
      @(negedge clk);
      load_start = 1'b0;
      chk("R8 busy rises", 64'(load_busy), 64'd1);
   endtask

   task automatic finish_load(input string req);
      while (!load_done) @(negedge clk);
      chk("R8 busy falls with done", 64'(load_busy), 64'd0);
      @(negedge clk);
      chk("R8 done is one pulse", 64'(load_done), 64'd0);
      chk({req, " read count"}, 64'(trace_n), 64'(exp_n));
      for (int i = 0; i < exp_n && i < trace_n; i++)
         if (trace[i] !== exp_trace[i]) chk({req, " read address"}, 64'(trace[i]), 64'(exp_trace[i]));
   endtask

   task automatic rand_phase(input int n);
      logic [47:0] a;
      int pick;
      for (int k = 0; k < n; k++) begin
         pick = int'($urandom_range(0, 7));
         if (pick < 3) a = ref_cam[$urandom_range(0, 15)];
         else if (pick == 3) a = {48{1'b1}};
         else a = {$urandom(), $urandom()} & 48'hFFFF_FFFF_FFFF;
         strobe_check("R4 random", a, 1'($urandom_range(0, 3) == 0),
                      1'($urandom_range(0, 3) == 0), 1'($urandom_range(0, 1)));
      end
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      int seed_dummy;
      logic [15:0] tgt;
      logic [47:0] old1;
      seed_dummy = $urandom(32'd4242);
      for (int i = 0; i < 1024; i++) mem[i] = 16'($urandom());
      for (int i = 0; i < 16; i++) ref_cam[i] = '0;
      mem[16'h0060 >> 1] = 16'h0007;   // mask after first list
      mem[16'h0230 >> 1] = 16'h000F;   // mask after wide list
      mem[16'h0100 >> 1] = 16'h0001;   // mask for empty list
      mem[16'h0488 >> 1] = 16'hFFFF;   // mask after 17-entry list
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R8 reset state
      chk("R8 reset busy", 64'(load_busy), 64'd0);
      chk("R5 reset valid", 64'(match_valid), 64'd0);
      reset_mode = 1'b1; cam_sel = 4'd5; cam_word = 2'd2; #1;
      chk("R9 reset table zero", 64'(cam_rd_data), 64'd0);
      reset_mode = 1'b0;
      strobe_check("R4 empty table rejects", 48'h0000_0000_0000, 0, 0, 0);
      @(negedge clk);
      chk("R5 valid drops", {62'd0, match_valid, match_accept}, 64'd0);

      // narrow list, count upper bits set (R6), start while busy ignored (R10)
      start_load(16'h0040, 16'h0024, 1'b0);
      @(negedge clk);
      load_ptr = 16'h0300; load_count = 16'h0001; load_start = 1'b1;
      @(negedge clk);
      load_start = 1'b0;
      finish_load("R10 R6 narrow");
      repeat (8) @(negedge clk);
      chk("R10 ignored start leaves idle", 64'(load_busy), 64'd0);

      strobe_check("R4 enabled entry", ref_cam[1], 0, 0, 0);
      strobe_check("R4 disabled entry", ref_cam[3], 0, 0, 0);
      strobe_check("R1 promisc unicast", 48'h1234_5678_9A00, 1, 0, 0);
      strobe_check("R1 promisc group falls through", 48'h1234_5678_9A01, 1, 0, 0);
      strobe_check("R2 all multicast", 48'h0000_0000_0033, 0, 1, 0);
      strobe_check("R3 broadcast", {48{1'b1}}, 0, 0, 1);
      strobe_check("R3 broadcast under multicast priority", {48{1'b1}}, 0, 1, 1);
      strobe_check("R3 broadcast not enabled", {48{1'b1}}, 0, 0, 0);

      // R9 read port
      @(negedge clk);
      reset_mode = 1'b1; cam_sel = 4'd2; cam_word = 2'd1; #1;
      chk("R9 word 1", 64'(cam_rd_data), 64'(ref_cam[2][31:16]));
      cam_word = 2'd0; #1;
      chk("R9 word 0", 64'(cam_rd_data), 64'(ref_cam[2][15:0]));
      cam_word = 2'd3; #1;
      chk("R9 word 3", 64'(cam_rd_data), 64'd0);
      cam_word = 2'd2; reset_mode = 1'b0; #1;
      chk("R9 closed outside reset mode", 64'(cam_rd_data), 64'd0);

      // wide list with a strobe at the entry-1 rewrite edge (R10, R7)
      old1 = ref_cam[1];
      tgt = 16'h0200 + 16'd16 + 16'd12;
      start_load(16'h0200, 16'h0003, 1'b1);
      while (!(mem_rd_en && mem_rd_addr == tgt)) @(negedge clk);
      @(negedge clk);
      mode_promisc = 0; mode_all_mcast = 0; mode_bcast = 0;
      dst_addr = old1; dst_valid = 1'b1;
      @(negedge clk);
      dst_valid = 1'b0;
      chk("R10 old entry at rewrite edge", {61'd0, match_valid, match_accept, match_kind[1]}, {61'd0, 3'b110});
      finish_load("R7 wide");
      strobe_check("R10 old entry gone", old1, 0, 0, 0);
      strobe_check("R7 wide entry 1", ref_cam[1], 0, 0, 0);
      strobe_check("R7 newly enabled entry 3", ref_cam[3], 0, 0, 0);

      // empty list: mask only (R7)
      start_load(16'h0100, 16'h0040, 1'b0);
      finish_load("R7 empty list");
      strobe_check("R7 mask only entry 0", ref_cam[0], 0, 0, 0);
      strobe_check("R7 mask only entry 1 off", ref_cam[1], 0, 0, 0);

      // 17 descriptors: index wraps (R7)
      start_load(16'h0400, 16'h0011, 1'b0);
      finish_load("R7 wrap");
      @(negedge clk);
      reset_mode = 1'b1; cam_sel = 4'd0; cam_word = 2'd2; #1;
      chk("R7 entry 0 from last descriptor", 64'(cam_rd_data), 64'(ref_cam[0][47:32]));
      reset_mode = 1'b0;
      rand_phase(300);

      repeat (4) @(negedge clk);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule